// File: doc/BRIEF.md
# Reverse Map Entry Address Locator

This block turns a system physical address into the memory address of the 16-byte ownership-table entry that describes its 4 KB page. If no such entry exists, it raises a not-covered flag instead. A request is accepted on a single-cycle valid strobe whenever the block is idle. The table base, table end and configuration inputs, and the segment-limit inputs, are sampled in that same accept cycle.

The table can have one of two layouts. In the linear layout, the entries sit directly behind a 16 KB bookkeeping area at the table base, and the result is ready one cycle after accept with no memory traffic. In the segmented layout, physical memory is cut into power-of-two segments. A 4 KB segment table behind the bookkeeping area holds one 8-byte descriptor per segment. The block reads that descriptor through a simple read port and then forms the entry address from the segment's own base. A descriptor whose mapped size is zero means the segment has no entries, and a mapped size below the segment size covers only the front part of the segment.

Each result comes with a one-cycle `done` pulse. The result stays stable until the next result is produced. Software is expected to keep the base and the end plus one 8 KB aligned, and the block does not check this.

Top module: `rev_map_locator`

## Requirements
- R1: While reset is asserted, `done`, `busy`, `rd_req`, `not_covered` and `entry_addr` are all zero.
- R2: Linear mode (`seg_cfg[0]`=0), covered address: one cycle after accept, `done`=1 and `not_covered`=0, with `entry_addr` = base + 16384 + (pa >> 12) × 16. No memory read is issued.
- R3: Linear mode: an address at or above ((end + 1 − base − 16384) / 16) × 4096 gives `not_covered`=1. When end + 1 − base ≤ 16384, every address is not covered. Whenever `not_covered`=1, `entry_addr` is 0.
- R4: Segmented mode (`seg_cfg[0]`=1, exponent E = `seg_cfg[13:8]`): with index i = pa >> E, one cycle after accept `rd_req` pulses for one cycle, with `rd_addr` = base + 16384 + i × 8 and `busy`=1.
- R5: Segmented mode: an index of 512 or more gives `not_covered`=1 one cycle after accept, with no read. Index 511 is still looked up.
- R6: Segmented mode: when `seg_cap_hard`=1, an index ≥ `seg_cap_cnt` is not covered and no read is issued. When `seg_cap_hard`=0, the count has no effect.
- R7: Segmented mode: one cycle after `rd_valid` is taken, `done`=1 and `entry_addr` = {d[51:20], 20'b0} + ((pa − (i << E)) >> 12) × 16, where d is `rd_data`. Bits 63:52 of d are ignored.
- R8: A descriptor whose mapped size d[19:0] is zero gives `not_covered`=1.
- R9: The address is not covered when its offset in the segment, pa − (i << E), is not below d[19:0] × 2^30.
- R10: Only one read is outstanding at a time. While `busy`=1, `req_valid` is ignored. `rd_valid` is considered only after the cycle in which `rd_req` was high.
- R11: `done` is a one-cycle pulse. `entry_addr` and `not_covered` change only in a cycle where `done`=1 and stay stable until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_pa | input | PA_W | System physical address to locate |
| tbl_base | input | PA_W | Address of the first byte of the table |
| tbl_end | input | PA_W | Address of the last byte of the table (linear mode) |
| seg_cfg | input | CFG_W | Bit 0 selects segmented mode, bits 13:8 hold the segment size exponent |
| seg_cap_hard | input | 1 | Segment count limit is enforced |
| seg_cap_cnt | input | CAP_W | Number of usable segments when the limit is enforced |
| busy | output | 1 | Segment descriptor read in progress |
| done | output | 1 | One-cycle result pulse |
| not_covered | output | 1 | No entry exists for the address |
| entry_addr | output | PA_W | Address of the 16-byte entry, 0 when not covered |
| rd_req | output | 1 | One-cycle descriptor read request |
| rd_addr | output | PA_W | Descriptor address |
| rd_valid | input | 1 | Descriptor data is valid |
| rd_data | input | DATA_W | Descriptor contents |

## Verification
The bench targets these corner cases:
- **Last covered page and first uncovered address.** A limit that is off by one page would either reject the last page or accept an address beyond the table.
- **Too-small table.** A design that subtracted without guarding would wrap around and claim the whole address space is covered.
- **Index range.** Index 511 must be looked up and 512 rejected with no read. The enforced segment limit must reject an index without a read, while the same index must be looked up once the limit flag is clear.
- **Descriptor decoding.** The bench uses an absent descriptor (mapped size 0), the last byte inside a partially mapped segment, the first byte past it, and noise in the unused high descriptor bits. A decoder that ignored the zero value, compared in the wrong unit or let the high bits leak into the base would return a wrong address or a wrong flag.
- **Requests while busy.** A request raised during a pending read must not start a second read or disturb the result.

// File: rtl/rml_pkg.sv
package rml_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rml_state_e;

  localparam int BOOK_LOG2    = 14;  // bookkeeping area size
  localparam int PAGE_LOG2    = 12;  // page covered by one entry
  localparam int ENTRY_LOG2   = 4;   // entry size
  localparam int SEGENT_LOG2  = 3;   // segment descriptor size
  localparam int MAX_SEGS     = 512;
  localparam int SEG_IDX_W    = $clog2(MAX_SEGS);
  localparam int GB_LOG2      = 30;
  localparam int MAPSZ_W      = 20;
  localparam int SEGBASE_LSB  = 20;
  localparam int SEGBASE_MSB  = 51;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_EXP_LSB  = 8;
  localparam int CFG_EXP_W    = 6;

endpackage

// File: rtl/rml_linear_calc.sv
module rml_linear_calc
  import rml_pkg::*;
#(
  parameter int PA_W = 52
) (
  input  logic [PA_W-1:0] base,
  input  logic [PA_W-1:0] last,
  input  logic [PA_W-1:0] pa,
  output logic            covered,
  output logic [PA_W-1:0] addr
);

  localparam int LW = PA_W + 13;

  logic [LW-1:0] top_w;
  logic [LW-1:0] low_w;
  logic [LW-1:0] span;
  logic [LW-1:0] limit;

  always_comb begin
    top_w   = LW'(last) + LW'(1);
    low_w   = LW'(base) + (LW'(1) << BOOK_LOG2);
    span    = top_w - low_w;
    limit   = (top_w > low_w) ? ((span >> ENTRY_LOG2) << PAGE_LOG2) : '0;
    covered = (LW'(pa) < limit);
    addr    = base + (PA_W'(1) << BOOK_LOG2) + ((pa >> PAGE_LOG2) << ENTRY_LOG2);
  end

endmodule

// File: rtl/rml_seg_index.sv
module rml_seg_index
  import rml_pkg::*;
#(
  parameter int PA_W  = 52,
  parameter int CAP_W = 10
) (
  input  logic [PA_W-1:0]      base,
  input  logic [PA_W-1:0]      pa,
  input  logic [CFG_EXP_W-1:0] seg_exp,
  input  logic                 cap_hard,
  input  logic [CAP_W-1:0]     cap_cnt,
  output logic                 idx_ok,
  output logic [PA_W-1:0]      tab_addr,
  output logic [PA_W-1:0]      offset
);

  logic [PA_W-1:0]      shifted;
  logic [PA_W-1:0]      mask;
  logic [SEG_IDX_W-1:0] idx;
  logic                 in_table;
  logic                 in_cap;

  always_comb begin
    for (int b = 0; b < PA_W; b++) begin
      mask[b] = (b < int'(seg_exp));
    end
  end

  always_comb begin
    shifted  = pa >> seg_exp;
    idx      = shifted[SEG_IDX_W-1:0];
    in_table = (shifted < PA_W'(MAX_SEGS));
    in_cap   = !cap_hard || (shifted < PA_W'(cap_cnt));
    idx_ok   = in_table && in_cap;
    offset   = pa & mask;
    tab_addr = base + (PA_W'(1) << BOOK_LOG2) + (PA_W'(idx) << SEGENT_LOG2);
  end

endmodule

// File: rtl/rml_seg_resolve.sv
module rml_seg_resolve
  import rml_pkg::*;
#(
  parameter int PA_W   = 52,
  parameter int DATA_W = 64
) (
  input  logic [PA_W-1:0]   offset,
  input  logic [DATA_W-1:0] desc,
  output logic              covered,
  output logic [PA_W-1:0]   addr
);

  localparam int LW = PA_W + GB_LOG2 + 1;

  logic [MAPSZ_W-1:0] mapped;
  logic [PA_W-1:0]    seg_base;
  logic [LW-1:0]      map_bytes;
  logic               desc_unused;

  assign desc_unused = ^desc[DATA_W-1:SEGBASE_MSB+1];

  always_comb begin
    mapped    = desc[MAPSZ_W-1:0];
    seg_base  = PA_W'(desc[SEGBASE_MSB:SEGBASE_LSB]) << SEGBASE_LSB;
    map_bytes = LW'(mapped) << GB_LOG2;
    covered   = (mapped != '0) && (LW'(offset) < map_bytes);
    addr      = seg_base + ((offset >> PAGE_LOG2) << ENTRY_LOG2);
  end

endmodule

// File: rtl/rev_map_locator.sv
module rev_map_locator
  import rml_pkg::*;
#(
  parameter int PA_W   = 52,
  parameter int CFG_W  = 16,
  parameter int CAP_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PA_W-1:0]   req_pa,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [PA_W-1:0]   tbl_end,
  input  logic [CFG_W-1:0]  seg_cfg,
  input  logic              seg_cap_hard,
  input  logic [CAP_W-1:0]  seg_cap_cnt,
  output logic              busy,
  output logic              done,
  output logic              not_covered,
  output logic [PA_W-1:0]   entry_addr,
  output logic              rd_req,
  output logic [PA_W-1:0]   rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);

  localparam int EXP_MSB = CFG_EXP_LSB + CFG_EXP_W - 1;

  rml_state_e state_q, state_d;
  logic            done_q, done_d;
  logic            nc_q, nc_d;
  logic [PA_W-1:0] addr_q, addr_d;
  logic            rd_req_q, rd_req_d;
  logic [PA_W-1:0] rd_addr_q, rd_addr_d;
  logic [PA_W-1:0] off_q, off_d;
  logic            res_en;
  logic            rd_en;

  logic            seg_mode;
  logic            lin_cov;
  logic [PA_W-1:0] lin_addr;
  logic            idx_ok;
  logic [PA_W-1:0] tab_addr;
  logic [PA_W-1:0] seg_off;
  logic            seg_cov;
  logic [PA_W-1:0] seg_addr;
  logic            cfg_unused;

  assign seg_mode   = seg_cfg[CFG_EN_BIT];
  assign cfg_unused = ^{seg_cfg[CFG_W-1:EXP_MSB+1], seg_cfg[CFG_EXP_LSB-1:CFG_EN_BIT+1]};

  rml_linear_calc #(.PA_W(PA_W)) lin_i (
    .base    (tbl_base),
    .last    (tbl_end),
    .pa      (req_pa),
    .covered (lin_cov),
    .addr    (lin_addr)
  );

  rml_seg_index #(.PA_W(PA_W), .CAP_W(CAP_W)) idx_i (
    .base     (tbl_base),
    .pa       (req_pa),
    .seg_exp  (seg_cfg[EXP_MSB:CFG_EXP_LSB]),
    .cap_hard (seg_cap_hard),
    .cap_cnt  (seg_cap_cnt),
    .idx_ok   (idx_ok),
    .tab_addr (tab_addr),
    .offset   (seg_off)
  );

  rml_seg_resolve #(.PA_W(PA_W), .DATA_W(DATA_W)) res_i (
    .offset  (off_q),
    .desc    (rd_data),
    .covered (seg_cov),
    .addr    (seg_addr)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    rd_req_d  = 1'b0;
    res_en    = 1'b0;
    nc_d      = nc_q;
    addr_d    = addr_q;
    rd_en     = 1'b0;
    rd_addr_d = rd_addr_q;
    off_d     = off_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!seg_mode) begin
            done_d = 1'b1;
            res_en = 1'b1;
            nc_d   = !lin_cov;
            addr_d = lin_cov ? lin_addr : '0;
          end else if (!idx_ok) begin
            done_d = 1'b1;
            res_en = 1'b1;
            nc_d   = 1'b1;
            addr_d = '0;
          end else begin
            rd_req_d  = 1'b1;
            rd_en     = 1'b1;
            rd_addr_d = tab_addr;
            off_d     = seg_off;
            state_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (rd_valid && !rd_req_q) begin
          done_d  = 1'b1;
          res_en  = 1'b1;
          nc_d    = !seg_cov;
          addr_d  = seg_cov ? seg_addr : '0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      rd_req_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      rd_req_q <= rd_req_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc_q   <= 1'b0;
      addr_q <= '0;
    end else if (res_en) begin
      nc_q   <= nc_d;
      addr_q <= addr_d;
    end
  end

  // read request registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      off_q     <= '0;
    end else if (rd_en) begin
      rd_addr_q <= rd_addr_d;
      off_q     <= off_d;
    end
  end

  assign busy        = (state_q == ST_WAIT);
  assign done        = done_q;
  assign not_covered = nc_q;
  assign entry_addr  = addr_q;
  assign rd_req      = rd_req_q;
  assign rd_addr     = rd_addr_q;

endmodule

// File: rtl/rml_checker.sv
module rml_checker #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            not_covered,
  input logic [PA_W-1:0] entry_addr,
  input logic            rd_req,
  input logic            rd_valid
);

  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
    end else if (rd_req) begin
      outstanding <= 1'b1;
    end else if (rd_valid && outstanding) begin
      outstanding <= 1'b0;
    end
  end

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outstanding);

  assert_busy_blocks_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(outstanding && rd_valid)) |=> !done);

  assert_read_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  assert_done_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding && rd_valid) |=> done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(entry_addr) && $stable(not_covered)));

  assert_nc_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && not_covered) |-> (entry_addr == '0));

endmodule

bind rev_map_locator rml_checker #(.PA_W(PA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .not_covered (not_covered),
  .entry_addr  (entry_addr),
  .rd_req      (rd_req),
  .rd_valid    (rd_valid)
);

// File: tb/rev_map_locator_tb_top.sv
module rev_map_locator_tb_top;

  localparam int PA_W = 52;
  localparam logic [51:0] BASE = 52'h10_0000;
  localparam logic [51:0] LAST = 52'h10_5FFF;

  typedef struct packed {
    logic        seg;
    logic        hard;
    logic [9:0]  cnt;
    logic [51:0] pa;
    logic        rd;
    logic [51:0] rda;
    logic        nc;
    logic [51:0] addr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 10'd0, 52'h0,            1'b0, 52'h0,      1'b0, 52'h10_4000,      8'd2}, // R2
    '{1'b0, 1'b0, 10'd0, 52'h1234,         1'b0, 52'h0,      1'b0, 52'h10_4010,      8'd2}, // R2
    '{1'b0, 1'b0, 10'd0, 52'h1F_FFFF,      1'b0, 52'h0,      1'b0, 52'h10_5FF0,      8'd3}, // R3 last page
    '{1'b0, 1'b0, 10'd0, 52'h20_0000,      1'b0, 52'h0,      1'b1, 52'h0,            8'd3}, // R3
    '{1'b0, 1'b0, 10'd0, 52'hFFFF_FFFF,    1'b0, 52'h0,      1'b1, 52'h0,            8'd3}, // R3
    '{1'b1, 1'b0, 10'd0, 52'h0,            1'b1, 52'h10_4000, 1'b0, 52'h4000_0000,    8'd4}, // R4
    '{1'b1, 1'b0, 10'd0, 52'h7FFF_FFFF,    1'b1, 52'h10_4000, 1'b0, 52'h407F_FFF0,    8'd9}, // R9
    '{1'b1, 1'b0, 10'd0, 52'h8000_0000,    1'b1, 52'h10_4000, 1'b1, 52'h0,            8'd9}, // R9
    '{1'b1, 1'b0, 10'd0, 52'h1_0000_0000,  1'b1, 52'h10_4008, 1'b1, 52'h0,            8'd8}, // R8
    '{1'b1, 1'b0, 10'd0, 52'h2_0000_1000,  1'b1, 52'h10_4010, 1'b0, 52'h8_0000_0010,  8'd7}, // R7
    '{1'b1, 1'b0, 10'd0, 52'h2_FFFF_F000,  1'b1, 52'h10_4010, 1'b0, 52'h8_00FF_FFF0,  8'd7}, // R7
    '{1'b1, 1'b0, 10'd0, 52'h1FF_0000_0000, 1'b1, 52'h10_4FF8, 1'b0, 52'h10_0000_0000, 8'd5}, // R5
    '{1'b1, 1'b0, 10'd0, 52'h200_0000_0000, 1'b0, 52'h0,      1'b1, 52'h0,            8'd5}, // R5
    '{1'b1, 1'b1, 10'd3, 52'h2_0000_1000,  1'b1, 52'h10_4010, 1'b0, 52'h8_0000_0010,  8'd6}, // R6
    '{1'b1, 1'b1, 10'd3, 52'h3_0000_0000,  1'b0, 52'h0,      1'b1, 52'h0,            8'd6}, // R6
    '{1'b1, 1'b0, 10'd3, 52'h3_0000_0000,  1'b1, 52'h10_4018, 1'b0, 52'h10_0000_0000, 8'd6}  // R6
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [PA_W-1:0]   req_pa;
  logic [PA_W-1:0]   tbl_base;
  logic [PA_W-1:0]   tbl_end;
  logic [15:0]       seg_cfg;
  logic              seg_cap_hard;
  logic [9:0]        seg_cap_cnt;
  logic              busy;
  logic              done;
  logic              not_covered;
  logic [PA_W-1:0]   entry_addr;
  logic              rd_req;
  logic [PA_W-1:0]   rd_addr;
  logic              rd_valid;
  logic [63:0]       rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  rev_map_locator dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_pa       (req_pa),
    .tbl_base     (tbl_base),
    .tbl_end      (tbl_end),
    .seg_cfg      (seg_cfg),
    .seg_cap_hard (seg_cap_hard),
    .seg_cap_cnt  (seg_cap_cnt),
    .busy         (busy),
    .done         (done),
    .not_covered  (not_covered),
    .entry_addr   (entry_addr),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // segment descriptors; default entry carries noise in bits 63:52
  function automatic logic [63:0] seg_desc(input logic [51:0] a);
    logic [51:0] i;
    i = (a - 52'h10_4000) >> 3;
    case (i)
      52'd0:   return 64'h0000_0000_4000_0002;
      52'd1:   return 64'h0000_0000_5000_0000;
      52'd2:   return 64'h0000_0008_0000_0004;
      default: return 64'hABC0_0010_0000_0004;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request and complete it; returns what was observed
  task automatic run_req(input logic seg, input logic hard, input logic [9:0] cnt,
                         input logic [51:0] pa, input int lat,
                         output logic o_rd, output logic [51:0] o_rda,
                         output logic o_done_early, output logic o_done,
                         output logic o_nc, output logic [51:0] o_addr);
    @(negedge clk);
    seg_cfg      = seg ? 16'h2001 : 16'h0000;
    seg_cap_hard = hard;
    seg_cap_cnt  = cnt;
    req_pa       = pa;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
    o_rd         = rd_req;
    o_rda        = rd_addr;
    o_done_early = done;
    if (rd_req) begin
      repeat (lat) @(negedge clk);
      rd_valid = 1'b1;
      rd_data  = seg_desc(o_rda);
      @(negedge clk);
      rd_valid = 1'b0;
    end
    o_done = done;
    o_nc   = not_covered;
    o_addr = entry_addr;
  endtask

  initial begin
    logic        o_rd, o_de, o_dn, o_nc;
    logic [51:0] o_rda, o_addr, held;
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_pa       = '0;
    tbl_base     = BASE;
    tbl_end      = LAST;
    seg_cfg      = '0;
    seg_cap_hard = 1'b0;
    seg_cap_cnt  = '0;
    rd_valid     = 1'b0;
    rd_data      = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rd_req", 64'(rd_req), 64'd0);
    chk("R1 not_covered", 64'(not_covered), 64'd0);
    chk("R1 entry_addr", 64'(entry_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      run_req(VECS[v].seg, VECS[v].hard, VECS[v].cnt, VECS[v].pa, (v % 3) + 1,
              o_rd, o_rda, o_de, o_dn, o_nc, o_addr);
      chk({tag, " read"}, 64'(o_rd), 64'(VECS[v].rd));
      if (VECS[v].rd) begin
        chk({tag, " rd_addr"}, 64'(o_rda), 64'(VECS[v].rda));
        chk({tag, " early done"}, 64'(o_de), 64'd0);
      end
      chk({tag, " done"}, 64'(o_dn), 64'd1);
      chk({tag, " not_covered"}, 64'(o_nc), 64'(VECS[v].nc));
      chk({tag, " entry_addr"}, 64'(o_addr), 64'(VECS[v].addr));
    end

    // R3 table no larger than the bookkeeping area, and end below base
    tbl_end = 52'h10_3FFF;
    run_req(1'b0, 1'b0, 10'd0, 52'h0, 1, o_rd, o_rda, o_de, o_dn, o_nc, o_addr);
    chk("R3 empty table nc", 64'(o_nc), 64'd1);
    tbl_end = 52'h0F_FFFF;
    run_req(1'b0, 1'b0, 10'd0, 52'h0, 1, o_rd, o_rda, o_de, o_dn, o_nc, o_addr);
    chk("R3 underflow nc", 64'(o_nc), 64'd1);
    chk("R3 underflow addr", 64'(o_addr), 64'd0);
    tbl_end = LAST;

    // R10 request while busy is ignored
    @(negedge clk);
    seg_cfg   = 16'h2001;
    seg_cap_hard = 1'b0;
    req_pa    = 52'h2_0000_1000;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R10 busy", 64'(busy), 64'd1);
    seg_cfg   = 16'h0000;
    req_pa    = 52'h0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 no done while busy", 64'(done), 64'd0);
    chk("R10 no second read", 64'(rd_req), 64'd0);
    rd_valid = 1'b1;
    rd_data  = seg_desc(52'h10_4010);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R10 done", 64'(done), 64'd1);
    chk("R10 first result kept", 64'(entry_addr), 64'h8_0000_0010);
    held = entry_addr;

    // R11 pulse and hold
    @(negedge clk);
    chk("R11 done pulse", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk("R11 addr held", 64'(entry_addr), 64'(held));
    chk("R11 nc held", 64'(not_covered), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule